// File: doc/BRIEF.md
# I2C Receive/Transmit Data Register Path

This block sits between a CPU register port and the bit shifter of an I2C bus interface. A completed receive frame leaves the shifter as a right-aligned group of bits with a bit count. The block aligns it according to the bit-order mode and hands it to a one-byte receive buffer that the CPU reads. If the buffer is still occupied when a new frame completes, the new frame is parked in a holding stage. It moves into the buffer only when the CPU reads the data register, so no received byte is lost. Byte data written by the CPU is aligned for the shifter in the same way.

The block also holds the slave address register. It compares the first frame after each start condition with the stored address and pulses a hit output on a match. Accesses to the data register are honoured only while the interface is enabled. Accesses to the address register are honoured only while it is disabled. SCL/SDA timing and the bus protocol state machine live elsewhere.

Top module: `i2c_dreg_top`

## Requirements
- R1: In receive mode with the interface enabled, a frame-complete strobe while the buffer is empty loads the aligned frame into the receive buffer, and `rx_full` reads 1 from the cycle after the strobe.
- R2: A frame that completes while `rx_full` is 1 is held without changing the buffer. A CPU read of the data register returns the older byte, moves the held frame into the buffer, and leaves `rx_full` at 1.
- R3: While `ctrl_rx_mode` is 0, a frame-complete strobe never loads the receive buffer or sets `rx_full`.
- R4: With `ctrl_lsb_first` at 0 and a frame of n bits (`frame_len` 1..8, where 0 means 8), the received bits are presented in the low n bits of the read data. `tx_word` carries the written byte shifted right by 8-n, which takes its upper n bits.
- R5: With `ctrl_lsb_first` at 1, the received n bits are presented in the upper n bits of the read data, shifted left by 8-n. `tx_word` carries the low n bits of the written byte.
- R6: A CPU read of the data register while the buffer is full and no frame is held clears `rx_full` on the next cycle. Nothing else clears it.
- R7: With `ctrl_en` at 0, data register writes leave `tx_word` unchanged, data register reads return 0x00, and frames are not accepted.
- R8: The address register (`reg_sel`=1) resets to 0x00. It is written and read only while `ctrl_en` is 0. While `ctrl_en` is 1, writes are ignored and reads return 0x00. Its bits 7:1 hold the slave address and bit 0 is the format select.
- R9: With the format-select bit at 0, the first frame after a start strobe whose bits 7:1 equal the stored slave address raises `addr_hit` for exactly one cycle, the cycle after the frame strobe. Later frames, frames with a non-matching address, and any frame while format-select is 1 give no pulse. A frame strobe in the same cycle as the start strobe is not the first frame.
- R10: A held frame is discarded on a start strobe or when `ctrl_en` is 0, so the next read empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_en | input | 1 | Interface enable |
| ctrl_rx_mode | input | 1 | 1 = receive mode, 0 = transmit mode |
| ctrl_lsb_first | input | 1 | Bit order: 0 = MSB first, 1 = LSB first |
| reg_sel | input | 1 | Register select: 0 = data, 1 = address |
| reg_wr | input | 1 | CPU write strobe |
| reg_rd | input | 1 | CPU read strobe |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | CPU read data, valid the cycle after the read strobe |
| frame_done | input | 1 | Frame-complete strobe from the shifter |
| frame_raw | input | 8 | Shifted bits, right-aligned |
| frame_len | input | 4 | Data bits per frame (1..8, 0 = 8) |
| start_det | input | 1 | Start-condition strobe |
| rx_full | output | 1 | Receive buffer full flag |
| tx_word | output | 8 | Aligned transmit bits for the shifter |
| addr_hit | output | 1 | One-cycle slave address match pulse |

## Verification
Every cycle, the checker confirms these properties: the full flag sets after an accepted frame, it never rises without one, and it stays set unless an enabled data read occurs. It also confirms that the address register is frozen while the interface is enabled, and that a hit pulse follows only an enabled frame with format-select at 0. Other behaviour can only be shown by bench scenarios:
- which byte a read returns, and the order of buffered and held frames;
- the alignment for each bit count and order;
- discarding a held frame on start or disable;
- the first-frame-only rule for the address match.

// File: rtl/i2c_dreg_pkg.sv
package i2c_dreg_pkg;
  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_ADDR = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/i2c_dreg_align.sv
module i2c_dreg_align #(
  parameter int DW = 8,
  parameter int LW = $clog2(DW + 1)
) (
  input  logic [LW-1:0] len,
  input  logic          lsb_first,
  input  logic [DW-1:0] rx_raw,
  input  logic [DW-1:0] tx_byte,
  output logic [DW-1:0] rx_just,
  output logic [DW-1:0] tx_just
);
  int            n;
  logic [DW-1:0] mask;

  // a count of zero or above the data width means a full-width frame
  assign n = (len == '0 || int'(len) > DW) ? DW : int'(len);

  generate
    for (genvar g = 0; g < DW; g++) begin : g_mask
      assign mask[g] = (g < n);
    end
  endgenerate

  always_comb begin
    if (lsb_first) begin
      rx_just = (rx_raw & mask) << (DW - n);
      tx_just = tx_byte & mask;
    end else begin
      rx_just = rx_raw & mask;
      tx_just = tx_byte >> (DW - n);
    end
  end
endmodule

// File: rtl/i2c_dreg_rxbuf.sv
module i2c_dreg_rxbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          take,
  input  logic          rd_ok,
  input  logic          flush,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] buf_q,
  output logic          full_q
);
  logic [DW-1:0] hold_q, buf_n, hold_n;
  logic          pend_q, pend_n, full_n, pend_v;

  always_comb begin
    pend_v = pend_q & en & ~flush;
    full_n = full_q;
    pend_n = pend_v;
    buf_n  = buf_q;
    hold_n = hold_q;
    // CPU read is resolved before a frame in the same cycle
    if (rd_ok && full_q) begin
      if (pend_v) begin
        buf_n  = hold_q;
        pend_n = 1'b0;
      end else begin
        full_n = 1'b0;
      end
    end
    if (take) begin
      if (!full_n) begin
        buf_n  = din;
        full_n = 1'b1;
      end else begin
        hold_n = din;
        pend_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      pend_q <= 1'b0;
      buf_q  <= '0;
      hold_q <= '0;
    end else begin
      full_q <= full_n;
      pend_q <= pend_n;
      buf_q  <= buf_n;
      hold_q <= hold_n;
    end
  end
endmodule

// File: rtl/i2c_dreg_addr.sv
module i2c_dreg_addr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          start,
  input  logic          frame_done,
  input  logic [DW-1:0] frame_raw,
  output logic [DW-1:0] addr_q,
  output logic          hit
);
  logic first_q;
  logic match;

  assign match = (frame_raw[DW-1:1] == addr_q[DW-1:1]) & ~addr_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      first_q <= 1'b0;
      hit     <= 1'b0;
    end else begin
      if (wr && !en) addr_q <= wdata;
      hit <= en & frame_done & first_q & ~start & match;
      if (!en)             first_q <= 1'b0;
      else if (start)      first_q <= 1'b1;
      else if (frame_done) first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_dreg_top.sv
module i2c_dreg_top #(
  parameter int DW = 8,
  parameter int LW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_en,
  input  logic          ctrl_rx_mode,
  input  logic          ctrl_lsb_first,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          frame_done,
  input  logic [DW-1:0] frame_raw,
  input  logic [LW-1:0] frame_len,
  input  logic          start_det,
  output logic          rx_full,
  output logic [DW-1:0] tx_word,
  output logic          addr_hit
);
  import i2c_dreg_pkg::*;

  reg_sel_e      sel;
  logic          data_rd, data_wr, addr_rd, addr_wr, take;
  logic [DW-1:0] rx_just, buf_q, addr_q, tx_q;

  assign sel     = reg_sel_e'(reg_sel);
  assign data_rd = reg_rd & (sel == SEL_DATA) & ctrl_en;
  assign data_wr = reg_wr & (sel == SEL_DATA) & ctrl_en;
  assign addr_rd = reg_rd & (sel == SEL_ADDR) & ~ctrl_en;
  assign addr_wr = reg_wr & (sel == SEL_ADDR);
  assign take    = ctrl_en & ctrl_rx_mode & frame_done;

  i2c_dreg_align #(.DW(DW), .LW(LW)) u_align (
    .len(frame_len), .lsb_first(ctrl_lsb_first),
    .rx_raw(frame_raw), .tx_byte(tx_q),
    .rx_just(rx_just), .tx_just(tx_word)
  );

  i2c_dreg_rxbuf #(.DW(DW)) u_rxbuf (
    .clk(clk), .rst(rst), .en(ctrl_en), .take(take), .rd_ok(data_rd),
    .flush(start_det), .din(rx_just), .buf_q(buf_q), .full_q(rx_full)
  );

  i2c_dreg_addr #(.DW(DW)) u_addr (
    .clk(clk), .rst(rst), .en(ctrl_en), .wr(addr_wr), .wdata(reg_wdata),
    .start(start_det), .frame_done(frame_done), .frame_raw(frame_raw),
    .addr_q(addr_q), .hit(addr_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q      <= '0;
      reg_rdata <= '0;
    end else begin
      if (data_wr) tx_q <= reg_wdata;
      if (reg_rd) begin
        if (data_rd)      reg_rdata <= buf_q;
        else if (addr_rd) reg_rdata <= addr_q;
        else              reg_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_dreg_chk.sv
module i2c_dreg_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ctrl_en,
  input logic          ctrl_rx_mode,
  input logic          frame_done,
  input logic          reg_rd,
  input logic          reg_sel,
  input logic          rx_full,
  input logic          addr_hit,
  input logic [DW-1:0] addr_q
);
  AST_RX_FILL: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && ctrl_rx_mode && frame_done && !rx_full) |=> rx_full); // R1
  AST_FULL_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !(reg_rd && !reg_sel && ctrl_en)) |=> rx_full); // R2
  AST_TX_NO_FILL: assert property (@(posedge clk) disable iff (rst)
    (!rx_full && !(ctrl_en && ctrl_rx_mode && frame_done)) |=> !rx_full); // R3
  AST_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_full) |-> $past(reg_rd && !reg_sel && ctrl_en)); // R6
  AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && $past(ctrl_en)) |-> $stable(addr_q)); // R8
  AST_HIT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    addr_hit |-> $past(frame_done && ctrl_en && !addr_q[0])); // R9
endmodule

bind i2c_dreg_top i2c_dreg_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .ctrl_rx_mode(ctrl_rx_mode),
  .frame_done(frame_done), .reg_rd(reg_rd), .reg_sel(reg_sel),
  .rx_full(rx_full), .addr_hit(addr_hit), .addr_q(addr_q)
);

// File: tb/test_i2c_dreg_top.sv
`timescale 1ns/1ps
module test_i2c_dreg_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_en = 1'b0, ctrl_rx_mode = 1'b1, ctrl_lsb_first = 1'b0;
  logic       reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, frame_raw = '0;
  logic [3:0] frame_len = 4'd8;
  logic       frame_done = 1'b0, start_det = 1'b0;
  logic [7:0] reg_rdata, tx_word;
  logic       rx_full, addr_hit;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic       m_full = 0, m_pend = 0, m_first = 0, m_hit = 0;
  logic [7:0] m_buf = 0, m_hold = 0, m_addr = 0, m_rdata = 0;

  always #2.5 clk = ~clk;

  i2c_dreg_top i_i2c_dreg_top (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .ctrl_rx_mode(ctrl_rx_mode),
    .ctrl_lsb_first(ctrl_lsb_first), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_done(frame_done), .frame_raw(frame_raw), .frame_len(frame_len),
    .start_det(start_det), .rx_full(rx_full), .tx_word(tx_word), .addr_hit(addr_hit)
  );

  function automatic int eff_len(logic [3:0] len);
    return (len == 0 || len > 8) ? 8 : int'(len);
  endfunction

  function automatic logic [7:0] exp_rx(logic [7:0] raw, logic [3:0] len, logic lsb);
    int n = eff_len(len);
    logic [7:0] m = 8'((16'h1 << n) - 1);
    return lsb ? 8'((raw & m) << (8 - n)) : (raw & m);
  endfunction

  function automatic logic [7:0] exp_tx(logic [7:0] w, logic [3:0] len, logic lsb);
    int n = eff_len(len);
    logic [7:0] m = 8'((16'h1 << n) - 1);
    return lsb ? (w & m) : 8'(w >> (8 - n));
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one clock; the reference follows the inputs applied in this cycle
  task automatic tick();
    logic take, rdok, pv;
    @(posedge clk);
    take = ctrl_en & ctrl_rx_mode & frame_done;
    rdok = reg_rd & !reg_sel & ctrl_en;
    pv   = m_pend & ctrl_en & !start_det;
    if (reg_rd) m_rdata = rdok ? m_buf : ((reg_sel && !ctrl_en) ? m_addr : 8'h00);
    m_hit = ctrl_en & frame_done & m_first & !start_det & !m_addr[0] &
            (frame_raw[7:1] == m_addr[7:1]);
    if (!ctrl_en) m_first = 0; else if (start_det) m_first = 1; else if (frame_done) m_first = 0;
    if (reg_wr && reg_sel && !ctrl_en) m_addr = reg_wdata;
    m_pend = pv;
    if (rdok && m_full) begin
      if (pv) begin m_buf = m_hold; m_pend = 0; end else m_full = 0;
    end
    if (take) begin
      if (!m_full) begin m_buf = exp_rx(frame_raw, frame_len, ctrl_lsb_first); m_full = 1; end
      else begin m_hold = exp_rx(frame_raw, frame_len, ctrl_lsb_first); m_pend = 1; end
    end
    @(negedge clk);
  endtask

  task automatic do_frame(logic [7:0] raw, logic [3:0] len);
    frame_raw = raw; frame_len = len; frame_done = 1; tick(); frame_done = 0;
  endtask
  task automatic do_read(logic sel, output logic [7:0] d);
    reg_sel = sel; reg_rd = 1; tick(); reg_rd = 0; d = reg_rdata;
  endtask
  task automatic do_write(logic sel, logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1; tick(); reg_wr = 0;
  endtask
  task automatic do_start();
    start_det = 1; tick(); start_det = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset full", {7'd0, rx_full}, 8'h00);
    check("R9 reset hit", {7'd0, addr_hit}, 8'h00);
    do_read(1, d); check("R8 addr reset", d, 8'h00);

    // address register gating
    do_write(1, 8'hA4);
    do_read(1, d); check("R8 addr write", d, 8'hA4);
    ctrl_en = 1; tick();
    do_write(1, 8'hFF);
    do_read(1, d); check("R8 addr read while enabled", d, 8'h00);
    ctrl_en = 0; tick();
    do_read(1, d); check("R8 addr unchanged", d, 8'hA4);
    ctrl_en = 1; tick();

    // basic receive and clear
    do_frame(8'h3C, 8);
    check("R1 full set", {7'd0, rx_full}, 8'h01);
    do_read(0, d); check("R1 data", d, 8'h3C);
    check("R6 full cleared", {7'd0, rx_full}, 8'h00);

    // deferred transfer
    do_frame(8'h11, 8); do_frame(8'h22, 8);
    do_read(0, d); check("R2 older byte", d, 8'h11);
    check("R2 still full", {7'd0, rx_full}, 8'h01);
    do_read(0, d); check("R2 held byte", d, 8'h22);
    check("R6 cleared after last", {7'd0, rx_full}, 8'h00);

    // transmit mode
    ctrl_rx_mode = 0; do_frame(8'h77, 8);
    check("R3 no fill in transmit", {7'd0, rx_full}, 8'h00);
    ctrl_rx_mode = 1;

    // alignment
    do_frame(8'h15, 5); do_read(0, d); check("R4 rx low-justified", d, 8'h15);
    ctrl_lsb_first = 1;
    do_frame(8'h15, 5); do_read(0, d); check("R5 rx high-justified", d, 8'hA8);
    do_write(0, 8'hAB); frame_len = 4;
    #1 check("R5 tx low bits", tx_word, 8'h0B);
    ctrl_lsb_first = 0;
    #1 check("R4 tx high bits", tx_word, 8'h0A);
    frame_len = 0;
    #1 check("R4 length 0 is 8", tx_word, 8'hAB);

    // enable gating of data register
    ctrl_en = 0; tick();
    do_write(0, 8'h55);
    #1 check("R7 write ignored", tx_word, 8'hAB);
    do_frame(8'h99, 8);
    check("R7 frame ignored", {7'd0, rx_full}, 8'h00);
    do_read(0, d); check("R7 read gives zero", d, 8'h00);
    ctrl_en = 1; tick();

    // address match (address 0x52, format select 0)
    do_start(); do_frame(8'hA5, 8);
    check("R9 hit", {7'd0, addr_hit}, 8'h01);
    tick(); check("R9 one cycle", {7'd0, addr_hit}, 8'h00);
    do_frame(8'hA4, 8);
    check("R9 not later frame", {7'd0, addr_hit}, 8'h00);
    do_start(); do_frame(8'hB4, 8);
    check("R9 mismatch", {7'd0, addr_hit}, 8'h00);
    ctrl_en = 0; tick(); do_write(1, 8'hA5); ctrl_en = 1; tick();
    do_start(); do_frame(8'hA4, 8);
    check("R9 format select 1", {7'd0, addr_hit}, 8'h00);
    ctrl_en = 0; tick(); do_write(1, 8'hA4); ctrl_en = 1; tick();
    do_read(0, d); do_read(0, d); do_read(0, d);

    // discard of held frame
    do_frame(8'h41, 8); do_frame(8'h42, 8); do_start();
    do_read(0, d); check("R10 start discards", d, 8'h41);
    check("R10 empty after read", {7'd0, rx_full}, 8'h00);
    do_frame(8'h43, 8); do_frame(8'h44, 8);
    ctrl_en = 0; tick(); ctrl_en = 1; tick();
    do_read(0, d); check("R10 disable discards", d, 8'h43);
    check("R10 empty", {7'd0, rx_full}, 8'h00);

    // random traffic against the reference
    for (int i = 0; i < 600; i++) begin
      int op = $urandom % 10;
      ctrl_rx_mode   = ($urandom % 8) != 0;
      ctrl_lsb_first = $urandom % 2;
      if (op < 4) do_frame(8'($urandom), 4'($urandom % 9));
      else if (op < 8) begin
        do_read(0, d); check("R2 random read", d, m_rdata);
      end else if (op == 8) do_start();
      else begin ctrl_en = ($urandom % 4) != 0; tick(); end
      check("R1 random full", {7'd0, rx_full}, {7'd0, m_full});
      check("R9 random hit", {7'd0, addr_hit}, {7'd0, m_hit});
    end

    done = 1;
    summary();
  end
endmodule